// File: doc/BRIEF.md
# Polled Keyboard Character Port

This block is a bus-slave peripheral that sits between a keyboard-side byte source and a processor bus. Each byte that arrives from the keyboard side is latched into a one-character holding slot and raises a ready flag. The processor polls a status word until that flag is set, then reads the character from a data word. The read is the acknowledgement: it clears the flag in hardware, so software never writes the status word between characters.

The keyboard side is a valid/ready stream whose ready output is always high. The port never applies back-pressure. A byte that arrives while the previous one is still unread replaces it, and a sticky overrun flag records the loss. The bus side is a plain read port. It takes an address and a read strobe, and it returns a registered read word in the cycle after the strobe. A cycle with the write strobe high is a write and changes nothing.

Top module: `kbdc_poll_port`

## Requirements
- R1: After reset the ready and overrun flags are clear and `bus_rdata` is zero.
- R2: A read (bus_rd high, bus_wr low) at address 0x0A00 returns the status word in the next cycle. Bit 15 is the ready flag, bit 14 is the overrun flag and all other bits are zero. Reading the status word changes no state.
- R3: A read at address 0x0A01 returns the held character in bits 7:0 in the next cycle, with bits 15:8 zero.
- R4: A cycle with key_valid high stores key_byte in the holding slot and sets the ready flag from the next cycle on.
- R5: A data-word read without an arrival in the same cycle clears both the ready and the overrun flag at that clock edge. The read returns the character held before the edge.
- R6: An arrival while ready is set, with no data read in that cycle, overwrites the held character and sets the overrun flag. The overrun flag stays set until a data read.
- R7: When an arrival and a data read fall in the same cycle, the read returns the old character, the new character is stored, ready stays set and overrun is cleared.
- R8: A read at any address other than 0x0A00 and 0x0A01 returns zero. In a cycle with no read, `bus_rdata` is zero in the next cycle.
- R9: Any cycle with bus_wr high is a write and is ignored at every address: no flag or character changes, and bus_rdata is zero in the next cycle.
- R10: key_ready is always high. Arrivals are never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | A keyboard byte is offered this cycle |
| key_byte | input | 8 | Keyboard byte value |
| key_ready | output | 1 | Always high; the port accepts every byte |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (writes are ignored) |
| bus_rdata | output | 16 | Registered read data, valid the cycle after the strobe |

## Verification
A wrong flag or a stale character inside the port can only be seen through a later read. The bench therefore interleaves status reads, data reads and arrivals densely, and keeps an independent model of the flags and the held byte. Any divergence then appears at bus_rdata on the next read of the affected word, one cycle after that strobe. A missed clear shows up as ready still set on the following status read. A lost overrun shows up as bit 14 missing. A wrong same-cycle priority shows up as either a dropped character or a stale ready flag.

// File: rtl/kbdc_pkg.sv
package kbdc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MISS = 2'd3
  } sel_e;
endpackage

// File: rtl/kbdc_decode.sv
module kbdc_decode
  import kbdc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0A00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0A01
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output sel_e              sel,
  output logic              data_take
);
  logic is_read;
  assign is_read = bus_rd && !bus_wr;

  always_comb begin
    if (!is_read)                    sel = SEL_NONE;
    else if (bus_addr == STAT_ADDR)  sel = SEL_STAT;
    else if (bus_addr == DATA_ADDR)  sel = SEL_DATA;
    else                             sel = SEL_MISS;
  end

  assign data_take = (sel == SEL_DATA);
endmodule

// File: rtl/kbdc_slot.sv
module kbdc_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_byte,
  input  logic              data_take,
  output logic [CHAR_W-1:0] char_q,
  output logic              ready_q,
  output logic              ovr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (key_valid) begin
        char_q  <= key_byte;
        ready_q <= 1'b1;
        if (data_take)    ovr_q <= 1'b0;
        else if (ready_q) ovr_q <= 1'b1;
      end else if (data_take) begin
        ready_q <= 1'b0;
        ovr_q   <= 1'b0;
      end
    end
  end

  AST_ARRIVAL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> ready_q); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_take && !key_valid) |=> (!ready_q && !ovr_q)); // R5
  AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && ready_q && !data_take) |=> ovr_q); // R6
  AST_TIE_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && data_take) |=> (ready_q && !ovr_q)); // R7
  AST_OVR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> ready_q); // R6
  AST_CHAR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(char_q)); // R9
endmodule

// File: rtl/kbdc_readout.sv
module kbdc_readout
  import kbdc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CHAR_W    = 8,
  parameter int READY_BIT = 15,
  parameter int OVR_BIT   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  logic [CHAR_W-1:0] char_q,
  input  logic              ready_q,
  input  logic              ovr_q,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAD_W = DATA_W - CHAR_W;

  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] data_word;
  logic [DATA_W-1:0] next_word;

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_stat
      if (b == READY_BIT)    begin : g_rdy assign stat_word[b] = ready_q; end
      else if (b == OVR_BIT) begin : g_ovr assign stat_word[b] = ovr_q;   end
      else                   begin : g_zero assign stat_word[b] = 1'b0;   end
    end
  endgenerate

  assign data_word = {{PAD_W{1'b0}}, char_q};

  always_comb begin
    case (sel)
      SEL_STAT: next_word = stat_word;
      SEL_DATA: next_word = data_word;
      default:  next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= next_word;
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MISS) |=> (bus_rdata == '0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> (bus_rdata == '0)); // R9
  AST_DATA_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DATA) |=> (bus_rdata[DATA_W-1:CHAR_W] == '0)); // R3
  AST_STAT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STAT) |=> (bus_rdata[READY_BIT] == $past(ready_q))); // R2
endmodule

// File: rtl/kbdc_poll_port.sv
module kbdc_poll_port
  import kbdc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h0A00,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'h0A01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [CHAR_W-1:0] key_byte,
  output logic              key_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int READY_BIT = DATA_W - 1;
  localparam int OVR_BIT   = DATA_W - 2;

  sel_e              sel;
  logic              data_take;
  logic [CHAR_W-1:0] char_q;
  logic              ready_q;
  logic              ovr_q;

  assign key_ready = 1'b1;

  kbdc_decode #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_decode (
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .sel(sel), .data_take(data_take)
  );

  kbdc_slot #(.CHAR_W(CHAR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_byte(key_byte),
    .data_take(data_take), .char_q(char_q), .ready_q(ready_q), .ovr_q(ovr_q)
  );

  kbdc_readout #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W), .READY_BIT(READY_BIT), .OVR_BIT(OVR_BIT)
  ) u_readout (
    .clk(clk), .rst_n(rst_n), .sel(sel), .char_q(char_q),
    .ready_q(ready_q), .ovr_q(ovr_q), .bus_rdata(bus_rdata)
  );

  AST_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !key_valid) |=> ($stable(ready_q) && $stable(ovr_q))); // R9
endmodule

// File: tb/kbdc_poll_port_test.sv
module kbdc_poll_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_STAT = 16'h0A00;
  localparam logic [15:0] A_DATA = 16'h0A01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_valid = 1'b0;
  logic [7:0] key_byte = '0;
  logic key_ready;
  logic [15:0] bus_addr = '0;
  logic bus_rd = 1'b0;
  logic bus_wr = 1'b0;
  logic [15:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic m_ready = 1'b0;
  logic m_ovr = 1'b0;
  logic [7:0] m_char = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbdc_poll_port uut (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_byte(key_byte),
    .key_ready(key_ready), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_rdata(bus_rdata)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_word(logic [15:0] a, logic rd, logic wr);
    if (!rd || wr) return 16'h0000;
    if (a == A_STAT) return {m_ready, m_ovr, 14'h0};
    if (a == A_DATA) return {8'h00, m_char};
    return 16'h0000;
  endfunction

  function automatic string auto_tag(logic [15:0] a, logic rd, logic wr);
    if (wr) return "R9";
    if (!rd) return "R8";
    if (a == A_STAT) return "R2";
    if (a == A_DATA) return "R3";
    return "R8";
  endfunction

  task automatic cyc(logic kv, logic [7:0] kb, logic [15:0] a, logic rd,
                     logic wr, string tag);
    logic [15:0] ew;
    logic take;
    string t;
    @(negedge clk);
    key_valid = kv; key_byte = kb; bus_addr = a; bus_rd = rd; bus_wr = wr;
    ew = exp_word(a, rd, wr);
    take = rd && !wr && (a == A_DATA);
    t = (tag == "") ? auto_tag(a, rd, wr) : tag;
    @(posedge clk);
    #1;
    chk(t, bus_rdata, ew);
    chk("R10", {15'h0, key_ready}, 16'h0001);
    if (kv) begin
      m_char = kb;
      if (take) m_ovr = 1'b0;
      else if (m_ready) m_ovr = 1'b1;
      m_ready = 1'b1;
    end else if (take) begin
      m_ready = 1'b0;
      m_ovr = 1'b0;
    end
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 16'h0000, 1'b0, 1'b0, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1A2B3C4D);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", bus_rdata, 16'h0000);
    // R1: status after reset is all zero
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R1");
    idle();
    // R4: arrival sets ready, R2 status read does not clear
    cyc(1'b1, 8'h41, 16'h0000, 1'b0, 1'b0, "R4");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R2");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R2");
    // R3 / R5: data read returns char then clears
    cyc(1'b0, 8'h00, A_DATA, 1'b1, 1'b0, "R3");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R5");
    // R6: overrun on double arrival, sticky across status reads
    cyc(1'b1, 8'h10, 16'h0000, 1'b0, 1'b0, "R4");
    cyc(1'b1, 8'h20, 16'h0000, 1'b0, 1'b0, "R6");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R6");
    idle();
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R6");
    cyc(1'b0, 8'h00, A_DATA, 1'b1, 1'b0, "R6");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R5");
    // R7: arrival and data read in the same cycle
    cyc(1'b1, 8'h55, 16'h0000, 1'b0, 1'b0, "R4");
    cyc(1'b1, 8'h66, 16'h0000, 1'b0, 1'b0, "R6");
    cyc(1'b1, 8'h77, A_DATA, 1'b1, 1'b0, "R7");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R7");
    cyc(1'b0, 8'h00, A_DATA, 1'b1, 1'b0, "R7");
    // R9: writes ignored, including write with read strobe at data address
    cyc(1'b1, 8'h99, 16'h0000, 1'b0, 1'b0, "R4");
    cyc(1'b0, 8'h00, A_DATA, 1'b1, 1'b1, "R9");
    cyc(1'b0, 8'h00, A_STAT, 1'b0, 1'b1, "R9");
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R9");
    cyc(1'b0, 8'h00, A_DATA, 1'b1, 1'b0, "R9");
    // R8: unmapped neighbours
    cyc(1'b0, 8'h00, 16'h0A02, 1'b1, 1'b0, "R8");
    cyc(1'b0, 8'h00, 16'h09FF, 1'b1, 1'b0, "R8");
    cyc(1'b0, 8'h00, 16'h8A01, 1'b1, 1'b0, "R8");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic kv, rd, wr;
      logic [7:0] kb;
      logic [15:0] a;
      int pick;
      kv = ($urandom % 4) == 0;
      kb = 8'($urandom);
      rd = ($urandom % 3) != 0;
      wr = ($urandom % 8) == 0;
      pick = $urandom % 6;
      if (pick < 2)      a = A_STAT;
      else if (pick < 4) a = A_DATA;
      else               a = 16'($urandom);
      cyc(kv, kb, a, rd, wr, "");
    end
    // drain: final state check
    cyc(1'b0, 8'h00, A_STAT, 1'b1, 1'b0, "R2");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule